// File: doc/BRIEF.md
# High-Register Move, Compare and Branch-Exchange Unit

This unit executes one group of 16-bit compressed instructions. These instructions can reach any of the sixteen 32-bit general registers because each operand carries one extra index bit. The unit recognises the group from the top six opcode bits and forms a 4-bit source index and a 4-bit destination index. It then does one of four things: a flagless add into the destination, a compare that updates the N/Z/C/V condition flags, a plain register move, or a branch-exchange. The branch-exchange loads the program counter (register 15) and sets the instruction-set state bit.

The register file sits outside the unit. The unit drives two read addresses from the instruction word and takes back the two read values in the same cycle. Results come out one cycle later on a registered write port: enable, index and data. The unit holds the condition flags and the state bit itself. A one-cycle pulse marks every program-counter write so that a fetch stage can flush. An opcode outside the group raises a one-cycle illegal flag and leaves all state alone.

Top module: `hireg_exec_unit`

## Requirements
- R1: An accepted word whose bits [15:10] differ from 6'b010001 raises `illegal_op` for exactly the following cycle, issues no register write and leaves the flags and state bit unchanged.
- R2: The source read address is {instr[6], instr[5:3]} and the destination read address is {instr[7], instr[2:0]}. Both are presented combinationally from `in_instr`.
- R3: Sub-op instr[9:8] = 2'b00 writes dst + src (modulo 2^32) into the destination register on the write port one cycle after acceptance, without touching the flags.
- R4: Sub-op 2'b01 (compare) computes dst - src modulo 2^32, issues no write, sets N (`flags_nzcv[3]`) to result bit 31 and sets Z (`flags_nzcv[2]`) exactly when the result is zero.
- R5: On compare, C (`flags_nzcv[1]`) is 1 exactly when src <= dst as unsigned numbers.
- R6: On compare, V (`flags_nzcv[0]`) is bit 31 of ((dst ^ result) & (~src ^ result)).
- R7: Sub-op 2'b10 (move) writes the source value into the destination register and keeps all four flags.
- R8: Sub-op 2'b11 (branch-exchange) sets `isa_state` to bit 0 of the source value and writes register 15 with the source value with bit 0 cleared.
- R9: `pc_written` is high for one cycle exactly when the write port carries a write to register 15. This happens on every branch-exchange and on any add or move whose destination is 15.
- R10: A cycle with `in_valid` low yields no write, no `pc_written` and no `illegal_op` in the next cycle, and changes no flag or state bit.
- R11: A synchronous active-high reset clears the flags, `isa_state`, `rf_we`, `pc_written` and `illegal_op`, even when an instruction is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is presented this cycle |
| in_instr | input | 16 | Instruction word |
| rf_raddr_src | output | 4 | Register-file read index, source operand |
| rf_raddr_dst | output | 4 | Register-file read index, destination operand |
| rf_rdata_src | input | 32 | Read value for the source index |
| rf_rdata_dst | input | 32 | Read value for the destination index |
| rf_we | output | 1 | Register write enable (registered) |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write value |
| flags_nzcv | output | 4 | Condition flags {N,Z,C,V} |
| isa_state | output | 1 | Instruction-set state bit |
| pc_written | output | 1 | One-cycle pulse on a write to register 15 |
| illegal_op | output | 1 | One-cycle pulse on an opcode outside the group |

## Verification
The hardest case to reach is a compare whose signed overflow differs from its unsigned borrow. The carry and overflow flags then disagree, and only particular operand pairs near 2^31 expose a wrong V term or a swapped C test. The vector table loads the model register file with such pairs, one on each side of the sign boundary and one using two high registers. It also steers adds and moves into register 15 so that the program-counter pulse is exercised outside the branch-exchange. A state bit set by an odd branch target is then cleared by a reset that arrives while another instruction is presented.

// File: rtl/hireg_pkg.sv
package hireg_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 4;
  localparam int TAG_W   = 6;
  localparam logic [TAG_W-1:0] CLASS_TAG = 6'b010001;
  localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

  typedef enum logic [1:0] {
    SUB_ADD = 2'b00,
    SUB_CMP = 2'b01,
    SUB_MOV = 2'b10,
    SUB_BX  = 2'b11
  } subop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/hireg_decode.sv
module hireg_decode
  import hireg_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               match,
  output subop_e             op,
  output logic [IDX_W-1:0]   src_idx,
  output logic [IDX_W-1:0]   dst_idx
);
  localparam int LO_W = IDX_W - 1;

  always_comb begin
    match   = (instr[INSTR_W-1 -: TAG_W] == CLASS_TAG);
    op      = subop_e'(instr[9:8]);
    src_idx = {instr[6], instr[2*LO_W-1 -: LO_W]};
    dst_idx = {instr[7], instr[LO_W-1:0]};
  end
endmodule

// File: rtl/hireg_alu.sv
module hireg_alu
  import hireg_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] dst_val,
  input  logic [W-1:0] src_val,
  output logic [W-1:0] sum,
  output nzcv_t        cmp_flags
);
  logic [W:0]   diff_ext;
  logic [W-1:0] diff;

  always_comb begin
    sum         = dst_val + src_val;
    diff_ext    = {1'b0, dst_val} - {1'b0, src_val};
    diff        = diff_ext[W-1:0];
    cmp_flags.n = diff[W-1];
    cmp_flags.z = (diff == '0);
    cmp_flags.c = ~diff_ext[W];
    cmp_flags.v = ((dst_val[W-1] ^ diff[W-1]) & (~src_val[W-1] ^ diff[W-1]));
  end
endmodule

// File: rtl/hireg_exec_unit.sv
module hireg_exec_unit
  import hireg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   in_instr,
  output logic [IDX_W-1:0]     rf_raddr_src,
  output logic [IDX_W-1:0]     rf_raddr_dst,
  input  logic [REG_W-1:0]     rf_rdata_src,
  input  logic [REG_W-1:0]     rf_rdata_dst,
  output logic                 rf_we,
  output logic [IDX_W-1:0]     rf_waddr,
  output logic [REG_W-1:0]     rf_wdata,
  output logic [3:0]           flags_nzcv,
  output logic                 isa_state,
  output logic                 pc_written,
  output logic                 illegal_op
);
  logic             dec_match;
  subop_e           dec_op;
  logic [IDX_W-1:0] dec_src, dec_dst;
  logic [REG_W-1:0] alu_sum;
  nzcv_t            alu_flags;
  nzcv_t            flags_q;

  hireg_decode u_decode (
    .instr   (in_instr),
    .match   (dec_match),
    .op      (dec_op),
    .src_idx (dec_src),
    .dst_idx (dec_dst)
  );

  hireg_alu #(.W(REG_W)) u_alu (
    .dst_val   (rf_rdata_dst),
    .src_val   (rf_rdata_src),
    .sum       (alu_sum),
    .cmp_flags (alu_flags)
  );

  assign rf_raddr_src = dec_src;
  assign rf_raddr_dst = dec_dst;
  assign flags_nzcv   = flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      isa_state  <= 1'b0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      pc_written <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      rf_we      <= 1'b0;
      pc_written <= 1'b0;
      illegal_op <= 1'b0;
      if (in_valid) begin
        if (!dec_match) begin
          illegal_op <= 1'b1;
        end else begin
          unique case (dec_op)
            SUB_ADD: begin
              rf_we      <= 1'b1;
              rf_waddr   <= dec_dst;
              rf_wdata   <= alu_sum;
              pc_written <= (dec_dst == PC_IDX);
            end
            SUB_CMP: begin
              flags_q <= alu_flags;
            end
            SUB_MOV: begin
              rf_we      <= 1'b1;
              rf_waddr   <= dec_dst;
              rf_wdata   <= rf_rdata_src;
              pc_written <= (dec_dst == PC_IDX);
            end
            SUB_BX: begin
              isa_state  <= rf_rdata_src[0];
              rf_we      <= 1'b1;
              rf_waddr   <= PC_IDX;
              rf_wdata   <= {rf_rdata_src[REG_W-1:1], 1'b0};
              pc_written <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hireg_exec_unit_chk.sv
module hireg_exec_unit_chk
  import hireg_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [INSTR_W-1:0]   in_instr,
  input logic [REG_W-1:0]     rf_rdata_src,
  input logic [REG_W-1:0]     rf_rdata_dst,
  input logic                 rf_we,
  input logic [IDX_W-1:0]     rf_waddr,
  input logic [REG_W-1:0]     rf_wdata,
  input logic [3:0]           flags_nzcv,
  input logic                 isa_state,
  input logic                 pc_written,
  input logic                 illegal_op
);
  logic in_class;
  logic [1:0] sub;
  assign in_class = (in_instr[15:10] == CLASS_TAG);
  assign sub      = in_instr[9:8];

  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_class) |=> (illegal_op && !rf_we && $stable(flags_nzcv) && $stable(isa_state)));

  a_r5_cmp_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class && sub == 2'b01) |=>
      (flags_nzcv[1] == ($past(rf_rdata_src) <= $past(rf_rdata_dst)) && !rf_we));

  a_r7_mov_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class && sub == 2'b10) |=> (rf_we && $stable(flags_nzcv)));

  a_r8_bx_target: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class && sub == 2'b11) |=>
      (rf_we && rf_waddr == PC_IDX && !rf_wdata[0] && isa_state == $past(rf_rdata_src[0])));

  a_r9_pulse_means_pc: assert property (@(posedge clk) disable iff (rst)
    pc_written |-> (rf_we && rf_waddr == PC_IDX));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!rf_we && !pc_written && !illegal_op && $stable(flags_nzcv)));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_nzcv == 4'b0 && !isa_state && !rf_we && !pc_written && !illegal_op));
endmodule

bind hireg_exec_unit hireg_exec_unit_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_instr     (in_instr),
  .rf_rdata_src (rf_rdata_src),
  .rf_rdata_dst (rf_rdata_dst),
  .rf_we        (rf_we),
  .rf_waddr     (rf_waddr),
  .rf_wdata     (rf_wdata),
  .flags_nzcv   (flags_nzcv),
  .isa_state    (isa_state),
  .pc_written   (pc_written),
  .illegal_op   (illegal_op)
);

// File: tb/hireg_exec_unit_tb.sv
module hireg_exec_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [15:0] instr;
    logic [31:0] sval;
    logic [31:0] dval;
    logic [3:0]  esrc;
    logic [3:0]  edst;
    logic        ewe;
    logic [3:0]  ewaddr;
    logic [31:0] ewdata;
    logic [3:0]  eflags;
    logic        epcw;
    logic        eill;
    logic        estate;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{16'h4411, 32'd5,          32'd7,          4'd2,  4'd1,  1'b1, 4'd1,  32'd12,         4'b0000, 1'b0, 1'b0, 1'b0}, // R3 add low
    '{16'h44E1, 32'hFFFFFFFF,   32'd2,          4'd12, 4'd9,  1'b1, 4'd9,  32'd1,          4'b0000, 1'b0, 1'b0, 1'b0}, // R3 wrap, R2 high
    '{16'h4518, 32'h10,         32'h10,         4'd3,  4'd0,  1'b0, 4'd0,  32'd0,          4'b0110, 1'b0, 1'b0, 1'b0}, // R4 Z
    '{16'h4518, 32'd2,          32'd1,          4'd3,  4'd0,  1'b0, 4'd0,  32'd0,          4'b1000, 1'b0, 1'b0, 1'b0}, // R5 borrow
    '{16'h4518, 32'd1,          32'h80000000,   4'd3,  4'd0,  1'b0, 4'd0,  32'd0,          4'b0011, 1'b0, 1'b0, 1'b0}, // R6 V with C
    '{16'h45F8, 32'hFFFFFFFF,   32'h7FFFFFFF,   4'd15, 4'd8,  1'b0, 4'd0,  32'd0,          4'b1001, 1'b0, 1'b0, 1'b0}, // R6 V no C
    '{16'h46AA, 32'hDEADBEEF,   32'd0,          4'd5,  4'd10, 1'b1, 4'd10, 32'hDEADBEEF,   4'b1001, 1'b0, 1'b0, 1'b0}, // R7 mov
    '{16'h4718, 32'h00000101,   32'd0,          4'd3,  4'd0,  1'b1, 4'd15, 32'h00000100,   4'b1001, 1'b1, 1'b0, 1'b1}, // R8 odd
    '{16'h468F, 32'h1234,       32'd0,          4'd1,  4'd15, 1'b1, 4'd15, 32'h1234,       4'b1001, 1'b1, 1'b0, 1'b1}, // R9 mov pc
    '{16'h449F, 32'h10,         32'h20,         4'd3,  4'd15, 1'b1, 4'd15, 32'h30,         4'b1001, 1'b1, 1'b0, 1'b1}, // R9 add pc
    '{16'h4770, 32'h08000000,   32'd5,          4'd14, 4'd0,  1'b1, 4'd15, 32'h08000000,   4'b1001, 1'b1, 1'b0, 1'b0}, // R8 even
    '{16'h4000, 32'd9,          32'd9,          4'd0,  4'd0,  1'b0, 4'd0,  32'd0,          4'b1001, 1'b0, 1'b1, 1'b0}, // R1
    '{16'h4800, 32'd9,          32'd9,          4'd0,  4'd0,  1'b0, 4'd0,  32'd0,          4'b1001, 1'b0, 1'b1, 1'b0}  // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_instr = 16'h0;
  logic [3:0]  rf_raddr_src, rf_raddr_dst;
  logic [31:0] rf_rdata_src, rf_rdata_dst;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic [3:0]  flags_nzcv;
  logic        isa_state, pc_written, illegal_op;
  logic [31:0] regs [16];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    rf_rdata_src = regs[rf_raddr_src];
    rf_rdata_dst = regs[rf_raddr_dst];
  end

  hireg_exec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .rf_raddr_src(rf_raddr_src), .rf_raddr_dst(rf_raddr_dst),
    .rf_rdata_src(rf_rdata_src), .rf_rdata_dst(rf_rdata_dst),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .flags_nzcv(flags_nzcv), .isa_state(isa_state),
    .pc_written(pc_written), .illegal_op(illegal_op)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic commit_write();
    if (rf_we) regs[rf_waddr] = rf_wdata;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 flags", {28'd0, flags_nzcv}, 32'd0);
    check("R11 state/pulses", {29'd0, isa_state, pc_written, illegal_op}, 32'd0);
    check("R11 we", {31'd0, rf_we}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      regs[TBL[i].esrc] = TBL[i].sval;
      if (TBL[i].edst != TBL[i].esrc) regs[TBL[i].edst] = TBL[i].dval;
      in_instr = TBL[i].instr;
      in_valid = 1'b1;
      #1;
      check("R2 src index", {28'd0, rf_raddr_src}, {28'd0, TBL[i].esrc});
      check("R2 dst index", {28'd0, rf_raddr_dst}, {28'd0, TBL[i].edst});
      @(negedge clk);
      in_valid = 1'b0;
      check("R3/R7/R8 write enable", {31'd0, rf_we}, {31'd0, TBL[i].ewe});
      if (TBL[i].ewe) begin
        check("R3/R7/R8 write index", {28'd0, rf_waddr}, {28'd0, TBL[i].ewaddr});
        check("R3/R7/R8 write data", rf_wdata, TBL[i].ewdata);
      end
      check("R4/R5/R6 flags", {28'd0, flags_nzcv}, {28'd0, TBL[i].eflags});
      check("R9 pc pulse", {31'd0, pc_written}, {31'd0, TBL[i].epcw});
      check("R1 illegal", {31'd0, illegal_op}, {31'd0, TBL[i].eill});
      check("R8 state bit", {31'd0, isa_state}, {31'd0, TBL[i].estate});
      commit_write();
      @(negedge clk);
      // R10 idle cycle: pulses drop, state holds
      check("R10 idle quiet", {29'd0, rf_we, pc_written, illegal_op}, 32'd0);
      check("R10 flags hold", {28'd0, flags_nzcv}, {28'd0, TBL[i].eflags});
    end

    // R8 written value lands in r15 of the model file
    check("R8 r15 content", regs[15], 32'h08000000);

    // R11 reset while an instruction is presented, after state set to 1
    @(negedge clk);
    regs[3] = 32'h00000201;
    in_instr = 16'h4718;
    in_valid = 1'b1;
    @(negedge clk);
    check("R8 state set", {31'd0, isa_state}, 32'd1);
    in_instr = 16'h4718;
    rst = 1'b1;
    @(negedge clk);
    check("R11 flags cleared", {28'd0, flags_nzcv}, 32'd0);
    check("R11 state cleared", {31'd0, isa_state}, 32'd0);
    check("R11 pulses cleared", {29'd0, rf_we, pc_written, illegal_op}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule